// File: doc/BRIEF.md
# Status Register Write-Protect Unit

This block keeps the write-control state of a serial, byte-addressed memory and decides, one request at a time, whether a write may go ahead. A command engine decodes the serial stream and hands it single-cycle pulses. These pulses are: raise the write-enable latch, drop it, write the status byte (with a data byte), attempt a memory byte write at a given address, and end a memory write operation. The block also watches an active-low hardware protect pin. It returns the status byte for readback, plus a single-cycle grant for each memory byte and for each status write.

Two status bits select how much of the upper address space is locked. One arming bit decides whether the protect pin may lock the status byte. The write-enable latch gates every write and drops by itself once a write has been accepted. The arming bit and the block-select bits would be nonvolatile in silicon. Here they are plain registers that load a parameter value at reset.

Top module: `wrprot_status_unit`

## Requirements
- R1: The status byte carries the arming bit at bit 7, the block-select field at bits 3:2 and the write-enable latch (WEL) at bit 1. Bits 6:4 and bit 0 always read 0, and no status write can set them.
- R2: During and right after reset, WEL is 0, both grants are 0, and bits 7 and 3:2 equal the same bits of the NV_RESET parameter.
- R3: A set-enable pulse makes WEL 1 and a clear-enable pulse makes it 0. If both arrive in the same cycle, the clear wins.
- R4: WEL drops to 0 after an accepted status write. It also drops at the end of a memory write operation in which at least one byte was granted. Bit 1 of the status write data never changes WEL.
- R5: While WEL is 0, no memory byte and no status write is granted.
- R6: A status write is refused when the arming bit is 1 and the protect pin is low. When the arming bit is 0, the pin level has no effect on status writes.
- R7: Block-select 00 locks nothing, 01 locks 1800h-1FFFh, 10 locks 1000h-1FFFh, and 11 locks the whole range. A byte address in a locked range is never granted.
- R8: A refused status write changes no status bit, WEL included. A memory write operation with no granted byte leaves WEL set.
- R9: Each byte of a sequential burst is judged on its own address. The bytes before a locked boundary are granted and the bytes from the boundary on are refused.
- R10: The protect pin has no effect on memory byte grants.
- R11: A grant is a one-cycle pulse in the cycle after its request pulse. The status byte shows the effect of a command in the cycle after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wren_i | input | 1 | Pulse: set the write-enable latch |
| cmd_wrdi_i | input | 1 | Pulse: clear the write-enable latch |
| cmd_wrsr_i | input | 1 | Pulse: status write request |
| wrsr_data_i | input | 8 | Data byte for the status write |
| cmd_memwr_i | input | 1 | Pulse: one memory byte write attempt |
| memwr_addr_i | input | ADDR_W | Byte address of the attempt |
| memwr_end_i | input | 1 | Pulse: memory write operation finished |
| wp_n_i | input | 1 | Active-low protect pin |
| status_o | output | 8 | Status byte for readback |
| mem_grant_o | output | 1 | Memory byte may be stored |
| sr_grant_o | output | 1 | Status write was accepted |

## Verification
Every result of this block is due exactly one clock after the pulse that causes it. The grants come from one register stage and the status byte comes straight from the state flops. The bench drives each command on a falling edge and lets one rising edge pass. On the next falling edge it compares the status byte and both grants against its own behavioural model, so every sample falls in the cycle the result is due. A burst runs one address per cycle, which places each grant directly against the address that produced it.

// File: rtl/wrprot_pkg.sv
package wrprot_pkg;
  localparam int SR_W      = 8;
  localparam int POS_ARM   = 7;
  localparam int POS_BLK_H = 3;
  localparam int POS_BLK_L = 2;
  localparam int POS_WEL   = 1;

  typedef enum logic [1:0] {
    BLK_NONE    = 2'b00,
    BLK_QUARTER = 2'b01,
    BLK_HALF    = 2'b10,
    BLK_ALL     = 2'b11
  } blk_sel_e;
endpackage

// File: rtl/wrprot_range_chk.sv
module wrprot_range_chk
  import wrprot_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  blk_sel_e          sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              locked_o
);
  localparam int TOP = ADDR_W - 1;

  // upper quarter: two top address bits set; upper half: top bit set
  always_comb begin
    unique case (sel_i)
      BLK_NONE:    locked_o = 1'b0;
      BLK_QUARTER: locked_o = addr_i[TOP] & addr_i[TOP-1];
      BLK_HALF:    locked_o = addr_i[TOP];
      default:     locked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wrprot_enable_latch.sv
module wrprot_enable_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic byte_ok_i,
  input  logic op_end_i,
  output logic wel_o
);
  logic wel_q;
  logic burst_ok_q;
  logic drop;

  // an operation only consumes the latch if it stored at least one byte
  assign drop = clr_i | (op_end_i & (burst_ok_q | byte_ok_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q      <= 1'b0;
      burst_ok_q <= 1'b0;
    end else begin
      if (op_end_i)       burst_ok_q <= 1'b0;
      else if (byte_ok_i) burst_ok_q <= 1'b1;

      if (drop)       wel_q <= 1'b0;
      else if (set_i) wel_q <= 1'b1;
    end
  end

  assign wel_o = wel_q;
endmodule

// File: rtl/wrprot_nv_bits.sv
module wrprot_nv_bits
  import wrprot_pkg::*;
#(
  parameter logic [SR_W-1:0] NV_RESET = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [SR_W-1:0] data_i,
  output logic            arm_o,
  output blk_sel_e        blk_o
);
  logic     arm_q;
  blk_sel_e blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= NV_RESET[POS_ARM];
      blk_q <= blk_sel_e'(NV_RESET[POS_BLK_H:POS_BLK_L]);
    end else if (load_i) begin
      arm_q <= data_i[POS_ARM];
      blk_q <= blk_sel_e'(data_i[POS_BLK_H:POS_BLK_L]);
    end
  end

  assign arm_o = arm_q;
  assign blk_o = blk_q;
endmodule

// File: rtl/wrprot_status_unit.sv
module wrprot_status_unit
  import wrprot_pkg::*;
#(
  parameter int              ADDR_W   = 13,
  parameter logic [SR_W-1:0] NV_RESET = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wren_i,
  input  logic              cmd_wrdi_i,
  input  logic              cmd_wrsr_i,
  input  logic [SR_W-1:0]   wrsr_data_i,
  input  logic              cmd_memwr_i,
  input  logic [ADDR_W-1:0] memwr_addr_i,
  input  logic              memwr_end_i,
  input  logic              wp_n_i,
  output logic [SR_W-1:0]   status_o,
  output logic              mem_grant_o,
  output logic              sr_grant_o
);
  logic     wel;
  logic     arm;
  blk_sel_e blk;
  logic     locked;
  logic     sr_ok;
  logic     byte_ok;
  logic     mem_grant_q;
  logic     sr_grant_q;

  wrprot_range_chk #(.ADDR_W(ADDR_W)) u_range (
    .sel_i    (blk),
    .addr_i   (memwr_addr_i),
    .locked_o (locked)
  );

  // pin locks the status byte only when armed
  assign sr_ok   = cmd_wrsr_i & wel & ~(arm & ~wp_n_i);
  // pin never reaches the array path
  assign byte_ok = cmd_memwr_i & wel & ~locked;

  wrprot_enable_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .set_i     (cmd_wren_i),
    .clr_i     (cmd_wrdi_i | sr_ok),
    .byte_ok_i (byte_ok),
    .op_end_i  (memwr_end_i),
    .wel_o     (wel)
  );

  wrprot_nv_bits #(.NV_RESET(NV_RESET)) u_nv (
    .clk    (clk),
    .rst    (rst),
    .load_i (sr_ok),
    .data_i (wrsr_data_i),
    .arm_o  (arm),
    .blk_o  (blk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_grant_q <= 1'b0;
      sr_grant_q  <= 1'b0;
    end else begin
      mem_grant_q <= byte_ok;
      sr_grant_q  <= sr_ok;
    end
  end

  // fixed-zero positions are filled by generate, live bits placed by index
  for (genvar b = 0; b < SR_W; b++) begin : g_sr
    if (b == POS_ARM) begin : g_arm
      assign status_o[b] = arm;
    end else if (b == POS_BLK_H) begin : g_bh
      assign status_o[b] = blk[1];
    end else if (b == POS_BLK_L) begin : g_bl
      assign status_o[b] = blk[0];
    end else if (b == POS_WEL) begin : g_wel
      assign status_o[b] = wel;
    end else begin : g_zero
      assign status_o[b] = 1'b0;
    end
  end

  assign mem_grant_o = mem_grant_q;
  assign sr_grant_o  = sr_grant_q;
endmodule

// File: rtl/wrprot_status_chk.sv
module wrprot_status_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_wren_i,
  input logic              cmd_wrdi_i,
  input logic              cmd_wrsr_i,
  input logic              cmd_memwr_i,
  input logic [ADDR_W-1:0] memwr_addr_i,
  input logic              memwr_end_i,
  input logic              wp_n_i,
  input logic [7:0]        status_o,
  input logic              mem_grant_o,
  input logic              sr_grant_o
);
  a_r1_fixed_zero: assert property (@(posedge clk) disable iff (rst)
    status_o[6:4] == 3'b000 && status_o[0] == 1'b0);

  a_r3_clear_wins: assert property (@(posedge clk) disable iff (rst)
    cmd_wrdi_i |=> !status_o[1]);

  a_r3_set: assert property (@(posedge clk) disable iff (rst)
    cmd_wren_i && !cmd_wrdi_i && !cmd_wrsr_i && !memwr_end_i |=> status_o[1]);

  a_r5_mem_needs_wel: assert property (@(posedge clk) disable iff (rst)
    cmd_memwr_i && !status_o[1] |=> !mem_grant_o);

  a_r5_sr_needs_wel: assert property (@(posedge clk) disable iff (rst)
    cmd_wrsr_i && !status_o[1] |=> !sr_grant_o);

  a_r6_pin_lock: assert property (@(posedge clk) disable iff (rst)
    cmd_wrsr_i && status_o[7] && !wp_n_i |=> !sr_grant_o);

  a_r7_all_locked: assert property (@(posedge clk) disable iff (rst)
    cmd_memwr_i && status_o[3:2] == 2'b11 |=> !mem_grant_o);

  a_r7_half_locked: assert property (@(posedge clk) disable iff (rst)
    cmd_memwr_i && status_o[3:2] == 2'b10 && memwr_addr_i[ADDR_W-1] |=> !mem_grant_o);

  a_r8_refused_stable: assert property (@(posedge clk) disable iff (rst)
    cmd_wrsr_i && !cmd_wren_i && !cmd_wrdi_i && !cmd_memwr_i && !memwr_end_i &&
    (!status_o[1] || (status_o[7] && !wp_n_i)) |=> $stable(status_o));

  a_r11_mem_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_grant_o |-> $past(cmd_memwr_i));

  a_r11_sr_pulse: assert property (@(posedge clk) disable iff (rst)
    sr_grant_o |-> $past(cmd_wrsr_i));

  a_r4_sr_drops_wel: assert property (@(posedge clk) disable iff (rst)
    sr_grant_o |-> !status_o[1]);
endmodule

bind wrprot_status_unit wrprot_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_wren_i   (cmd_wren_i),
  .cmd_wrdi_i   (cmd_wrdi_i),
  .cmd_wrsr_i   (cmd_wrsr_i),
  .cmd_memwr_i  (cmd_memwr_i),
  .memwr_addr_i (memwr_addr_i),
  .memwr_end_i  (memwr_end_i),
  .wp_n_i       (wp_n_i),
  .status_o     (status_o),
  .mem_grant_o  (mem_grant_o),
  .sr_grant_o   (sr_grant_o)
);

// File: tb/tb_wrprot_status_unit.sv
module tb_wrprot_status_unit;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wren = 0, wrdi = 0, wrsr = 0, memwr = 0, wend = 0, wp_n = 1;
  logic [7:0]    sdat = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    status;
  logic          mgnt, sgnt;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural model state
  int m_wel = 0, m_arm = 0, m_blk = 0, m_burst = 0;
  int e_mg = 0, e_sg = 0;

  always #4 clk = ~clk;

  wrprot_status_unit #(.ADDR_W(AW), .NV_RESET(8'h00)) dut (
    .clk(clk), .rst(rst), .cmd_wren_i(wren), .cmd_wrdi_i(wrdi),
    .cmd_wrsr_i(wrsr), .wrsr_data_i(sdat), .cmd_memwr_i(memwr),
    .memwr_addr_i(addr), .memwr_end_i(wend), .wp_n_i(wp_n),
    .status_o(status), .mem_grant_o(mgnt), .sr_grant_o(sgnt)
  );

  function automatic logic [7:0] model_status();
    return {m_arm[0], 3'b000, m_blk[1:0], m_wel[0], 1'b0};
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // one command cycle: drive, advance model, compare on next falling edge
  task automatic step(input string tag, input bit s_en, input bit c_en,
                      input bit sw, input logic [7:0] d, input bit mw,
                      input int a, input bit fin, input bit pin);
    int lock;
    bit accept;
    wren = s_en; wrdi = c_en; wrsr = sw; sdat = d; memwr = mw;
    addr = AW'(a); wend = fin; wp_n = pin;
    e_mg = 0; e_sg = 0;
    if (mw) begin
      lock = (m_blk == 3) || (m_blk == 2 && a >= 'h1000) || (m_blk == 1 && a >= 'h1800);
      e_mg = (m_wel == 1 && lock == 0) ? 1 : 0;
    end
    accept = sw && m_wel == 1 && !(m_arm == 1 && !pin);
    e_sg = accept ? 1 : 0;
    if (accept) begin
      m_arm = d[7];
      m_blk = d[3:2];
    end
    if (c_en || accept || (fin && (m_burst == 1 || e_mg == 1))) m_wel = 0;
    else if (s_en) m_wel = 1;
    if (fin) m_burst = 0;
    else if (e_mg == 1) m_burst = 1;
    @(negedge clk);
    check({tag, " status"}, status, model_status());
    check({tag, " mem_grant"}, mgnt, e_mg);
    check({tag, " sr_grant"}, sgnt, e_sg);
    wren = 0; wrdi = 0; wrsr = 0; memwr = 0; wend = 0;
  endtask

  task automatic wr_byte(input string tag, input int a, input bit pin);
    step(tag, 0, 0, 0, 8'h00, 1, a, 0, pin);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state visible while reset is held and right after release
    check("R2 status in reset", status, 0);
    check("R2 grants in reset", {mgnt, sgnt}, 0);
    rst = 1'b0;
    step("R2 idle after reset", 0, 0, 0, 8'h00, 0, 0, 0, 1);

    // R5: nothing granted without WEL
    wr_byte("R5 mem write no WEL", 'h0000, 1);
    step("R5 R8 status write no WEL", 0, 0, 1, 8'h8C, 0, 0, 0, 1);

    // R3: set and clear the latch, clear wins on collision
    step("R3 set", 1, 0, 0, 8'h00, 0, 0, 0, 1);
    step("R3 clear", 0, 1, 0, 8'h00, 0, 0, 0, 1);
    step("R3 set+clear", 1, 1, 0, 8'h00, 0, 0, 0, 1);
    step("R3 set again", 1, 0, 0, 8'h00, 0, 0, 0, 1);

    // R1 R4 R6 R11: unarmed, pin low ignored, reserved bits and bit1 stay out
    step("R1 R4 R6 R11 accepted status write", 0, 0, 1, 8'hFF, 0, 0, 0, 0);
    step("R11 grant is one cycle", 0, 0, 0, 8'h00, 0, 0, 0, 1);

    // R7: all locked, even with WEL
    step("R7 set", 1, 0, 0, 8'h00, 0, 0, 0, 1);
    wr_byte("R7 all locked low", 'h0000, 1);
    wr_byte("R7 all locked high", 'h1FFF, 1);

    // R6 R8: armed and pin low refuses, WEL kept
    step("R6 R8 pin lock", 0, 0, 1, 8'h04, 0, 0, 0, 0);
    step("R6 pin high accepts", 0, 0, 1, 8'h04, 0, 0, 0, 1);

    // R9 R10 R4: quarter lock burst across boundary with pin low
    step("R9 set", 1, 0, 0, 8'h00, 0, 0, 0, 1);
    wr_byte("R9 R10 byte 17FE", 'h17FE, 0);
    wr_byte("R9 R10 byte 17FF", 'h17FF, 0);
    wr_byte("R9 byte 1800", 'h1800, 0);
    wr_byte("R9 byte 1801", 'h1801, 0);
    step("R4 end of write op", 0, 0, 0, 8'h00, 0, 0, 1, 1);

    // R7: half lock
    step("R7 set", 1, 0, 0, 8'h00, 0, 0, 0, 1);
    step("R7 select half", 0, 0, 1, 8'h08, 0, 0, 0, 1);
    step("R7 set", 1, 0, 0, 8'h00, 0, 0, 0, 1);
    wr_byte("R7 half 0FFF open", 'h0FFF, 1);
    wr_byte("R7 half 1000 locked", 'h1000, 1);
    step("R4 end", 0, 0, 0, 8'h00, 0, 0, 1, 1);

    // R8: operation with no granted byte keeps WEL
    step("R8 set", 1, 0, 0, 8'h00, 0, 0, 0, 1);
    wr_byte("R8 locked byte", 'h1234, 1);
    step("R8 end keeps WEL", 0, 0, 0, 8'h00, 0, 0, 1, 1);

    // R7: no lock, R10 pin low still grants
    step("R7 select none", 0, 0, 1, 8'h00, 0, 0, 0, 0);
    step("R7 set", 1, 0, 0, 8'h00, 0, 0, 0, 1);
    wr_byte("R7 R10 none 1FFF", 'h1FFF, 0);
    step("R4 end", 0, 0, 0, 8'h00, 0, 0, 1, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule